// File: doc/BRIEF.md
# ADC Convert and Bit-Clock Timing Generator

This block produces the three control waveforms that pace an oversampling stereo ADC ahead of a decimation filter. There is a convert strobe, a bit-clock control line and an input bit clock. All three are timed by a clock enable, `tick_i`, that pulses at 256 times the output sample rate fs. The same enable rate is used whatever crystal ratio the clock divider upstream was built for. One free-running position counter sets the frame, and each output is a registered decode of that position.

Two static selects shape the waveforms. `dec4_i` picks decimation by four, where a frame of 64 ticks is one converter sample at 4fs. Clearing it picks decimation by two, where a frame of 128 ticks is one sample at 2fs. Internally every frame has 64 positions, called units. A unit is one tick under decimation by four and two ticks under decimation by two, so all widths, periods and offsets double when the ratio halves. `wide_i` picks the 32-clock pattern used with 18-bit converters. Clearing it picks the 16-clock pattern used with 16-bit converters. A select that changes mid-frame is held off until the next frame boundary, so no runt pulse can appear.

The control flow is a two-state machine. `ST_IDLE` is entered by reset and keeps every output low. Transition START (`ST_IDLE` to `ST_RUN`) happens on the first tick: the selects are sampled and the position is set to 0. In `ST_RUN`, transition STEP advances the position on each tick. Transition WRAP (`ST_RUN` to `ST_RUN`) happens on the tick at the last position of a frame: the position returns to 0 and the selects are sampled again.

Top module: `adc_strobe_gen`

## Requirements
- R1: After reset every output is low, and all stay low until the first tick. That tick starts the first frame at unit 0, and its outputs appear one clock later.
- R2: A frame is 64 ticks when `dec4_i`=1 and 128 ticks when `dec4_i`=0. The convert strobe rises exactly once per frame, at unit 0.
- R3: In the 32-clock pattern (`wide_i`=1), the convert strobe is high for unit 0 only.
- R4: In the 32-clock pattern, `bitctl_o` is high on odd units and `bitclk_o` is high on even units. This gives 32 rising edges of each per frame, with a period of 2 units.
- R5: In the 16-clock pattern (`wide_i`=0), the convert strobe is high for units 0 to 31, which is half the frame.
- R6: In the 16-clock pattern, `bitctl_o` is high when (unit mod 4) < 2 and `bitclk_o` is high otherwise. This gives 16 rising edges of each per frame, with `bitclk_o` lagging `bitctl_o` by 2 units.
- R7: A unit is 1 tick when `dec4_i`=1 and 2 ticks when `dec4_i`=0, so every width, period and offset doubles under decimation by two.
- R8: `dec4_i` and `wide_i` are sampled only at START and at WRAP. A change inside a frame has no effect on that frame.
- R9: Outputs are registered. They change only on the clock after a tick that moves the position, and they hold while no tick arrives.
- R10: Reset asserted while running drives all outputs low on the next clock and returns the machine to `ST_IDLE`. The next tick restarts the frame at unit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Clock enable at 256 fs |
| dec4_i | input | 1 | 1: decimate by 4 (64-tick frame), 0: decimate by 2 (128-tick frame) |
| wide_i | input | 1 | 1: 32-clock pattern, 0: 16-clock pattern |
| conv_o | output | 1 | Convert strobe |
| bitctl_o | output | 1 | Bit-clock control waveform |
| bitclk_o | output | 1 | Input bit clock |

## Verification
The hardest situation to reach from the ports is a select change that lands inside a frame. The old pattern must run to completion while the new one is already present on the pins. The bench reaches this by waiting for a convert rise and then flipping `wide_i` or `dec4_i` a fixed number of clocks later. It then counts edges and the frame length over that frame and over the following one. Irregular tick gaps from a shift register, a long tick-free stretch and a reset issued mid-frame cover holding and restart, while a behavioural model is compared on every clock.

// File: rtl/adc_strobe_pkg.sv
package adc_strobe_pkg;

    // control state of the frame sequencer
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } frame_state_e;

    // mode captured at a frame boundary
    typedef struct packed {
        logic dec4;   // 1: 64-tick frame, 0: 128-tick frame
        logic wide;   // 1: 32 clocks per frame, 0: 16 clocks per frame
    } frame_mode_t;

    // registered output bundle
    typedef struct packed {
        logic conv;
        logic bitctl;
        logic bitclk;
    } strobe_wave_t;

    localparam int DEF_FRAME_UNITS   = 64;
    localparam int DEF_NARROW_CONV   = 32;
    localparam int DEF_NARROW_PERIOD = 4;
    localparam int DEF_WIDE_PERIOD   = 2;

endpackage

// File: rtl/adc_strobe_frame.sv
module adc_strobe_frame
    import adc_strobe_pkg::*;
#(
    parameter int FRAME_UNITS = DEF_FRAME_UNITS,
    parameter int CNT_W       = $clog2(2 * FRAME_UNITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  frame_mode_t      mode_i,
    output logic [CNT_W-1:0] pos_o,
    output frame_mode_t      mode_o,
    output logic             run_o
);

    localparam logic [CNT_W-1:0] LAST_DEC4 = CNT_W'(FRAME_UNITS - 1);
    localparam logic [CNT_W-1:0] LAST_DEC2 = CNT_W'(2 * FRAME_UNITS - 1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    frame_mode_t      mode_q;
    logic [CNT_W-1:0] last_pos;
    logic             at_end;
    logic             reload;

    assign last_pos = mode_q.dec4 ? LAST_DEC4 : LAST_DEC2;
    assign at_end   = (state_q == ST_RUN) && (cnt_q == last_pos);
    // START and WRAP both reload the mode and zero the position
    assign reload   = (state_q == ST_IDLE) || at_end;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick_i) state_d = ST_RUN;   // START
            ST_RUN:  state_d = ST_RUN;               // STEP / WRAP
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // position counter and boundary-sampled mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= '0;
        end else if (tick_i) begin
            if (reload) begin
                cnt_q  <= '0;
                mode_q <= mode_i;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign pos_o  = cnt_q;
    assign mode_o = mode_q;
    assign run_o  = (state_q == ST_RUN);

    // R1: first tick starts the frame at position 0
    a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tick_i) |=> (state_q == ST_RUN && cnt_q == '0));

    // R2: the last position wraps to zero on a tick
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && at_end) |=> (cnt_q == '0));

    // R2: the position never passes the frame end
    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= last_pos));

    // R8: the mode moves only at a frame boundary
    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !(tick_i && at_end)) |=> $stable(mode_q));

endmodule

// File: rtl/adc_strobe_decode.sv
module adc_strobe_decode
    import adc_strobe_pkg::*;
#(
    parameter int FRAME_UNITS   = DEF_FRAME_UNITS,
    parameter int NARROW_CONV   = DEF_NARROW_CONV,
    parameter int NARROW_PERIOD = DEF_NARROW_PERIOD,
    parameter int WIDE_PERIOD   = DEF_WIDE_PERIOD,
    parameter int CNT_W         = $clog2(2 * FRAME_UNITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] pos_i,
    input  frame_mode_t      mode_i,
    output strobe_wave_t     wave_o
);

    localparam int UNIT_W = CNT_W - 1;
    localparam int NB     = $clog2(NARROW_PERIOD);
    localparam int WB     = $clog2(WIDE_PERIOD);

    logic [UNIT_W-1:0] unit;
    logic [NB-1:0]     nph;
    logic [WB-1:0]     wph;
    strobe_wave_t      wave_d, wave_q;

    // a unit is one tick at decimate-by-4, two ticks at decimate-by-2
    assign unit = mode_i.dec4 ? pos_i[UNIT_W-1:0] : pos_i[UNIT_W:1];
    assign nph  = unit[NB-1:0];
    assign wph  = unit[WB-1:0];

    always_comb begin
        wave_d = '0;
        if (run_i) begin
            unique case (mode_i.wide)
                1'b1: begin
                    wave_d.conv   = (unit == '0);
                    wave_d.bitctl = (wph >= WB'(WIDE_PERIOD / 2));
                    wave_d.bitclk = (wph <  WB'(WIDE_PERIOD / 2));
                end
                default: begin
                    wave_d.conv   = (unit < UNIT_W'(NARROW_CONV));
                    wave_d.bitctl = (nph <  NB'(NARROW_PERIOD / 2));
                    wave_d.bitclk = (nph >= NB'(NARROW_PERIOD / 2));
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= '0;
        else        wave_q <= wave_d;
    end

    assign wave_o = wave_q;

    // R1: outputs stay low while the sequencer is idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (wave_q == '0));

    // R6: the two bit clocks are never high together
    a_r6_clocks_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(wave_q.bitctl && wave_q.bitclk));

    // R9: no position change means no output change
    a_r9_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pos_i) && $stable(mode_i) && $stable(run_i)) |=> $stable(wave_q));

endmodule

// File: rtl/adc_strobe_gen.sv
module adc_strobe_gen
    import adc_strobe_pkg::*;
#(
    parameter int FRAME_UNITS   = DEF_FRAME_UNITS,
    parameter int NARROW_CONV   = DEF_NARROW_CONV,
    parameter int NARROW_PERIOD = DEF_NARROW_PERIOD,
    parameter int WIDE_PERIOD   = DEF_WIDE_PERIOD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic dec4_i,
    input  logic wide_i,
    output logic conv_o,
    output logic bitctl_o,
    output logic bitclk_o
);

    localparam int CNT_W = $clog2(2 * FRAME_UNITS);

    frame_mode_t      mode_in, mode_cur;
    logic [CNT_W-1:0] pos;
    logic             run;
    strobe_wave_t     wave;

    assign mode_in.dec4 = dec4_i;
    assign mode_in.wide = wide_i;

    adc_strobe_frame #(
        .FRAME_UNITS (FRAME_UNITS),
        .CNT_W       (CNT_W)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .mode_i (mode_in),
        .pos_o  (pos),
        .mode_o (mode_cur),
        .run_o  (run)
    );

    adc_strobe_decode #(
        .FRAME_UNITS   (FRAME_UNITS),
        .NARROW_CONV   (NARROW_CONV),
        .NARROW_PERIOD (NARROW_PERIOD),
        .WIDE_PERIOD   (WIDE_PERIOD),
        .CNT_W         (CNT_W)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .pos_i  (pos),
        .mode_i (mode_cur),
        .wave_o (wave)
    );

    assign conv_o   = wave.conv;
    assign bitctl_o = wave.bitctl;
    assign bitclk_o = wave.bitclk;

    // R10: reset silences every output on the next clock
    a_r10_reset_low: assert property (@(posedge clk)
        $past(!rst_n) |-> !(conv_o || bitctl_o || bitclk_o));

    // R2: the convert strobe rises only out of a running frame
    a_r2_conv_rise_running: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> $past(run));

endmodule

// File: tb/adc_strobe_gen_bench.sv
module adc_strobe_gen_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic tick  = 1'b0;
    logic dec4  = 1'b1;
    logic wide  = 1'b1;
    logic conv_o, bitctl_o, bitclk_o;

    adc_strobe_gen u_adc_strobe_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .dec4_i   (dec4),
        .wide_i   (wide),
        .conv_o   (conv_o),
        .bitctl_o (bitctl_o),
        .bitclk_o (bitclk_o)
    );

    int compared = 0;
    int mismatched = 0;
    bit cmp_en = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // expected {conv, bitctl, bitclk} for a tick position and mode
    function automatic logic [2:0] exp_wave(int pos, bit d4, bit w);
        int u;
        logic c, b;
        u = d4 ? pos : pos / 2;
        if (w) begin
            c = (u == 0);
            b = (u % 2) == 1;
        end else begin
            c = (u < 32);
            b = (u % 4) < 2;
        end
        return {c, b, !b};
    endfunction

    // behavioural reference, advanced on every clock
    bit       r_run = 0;
    int       r_pos = 0;
    bit       r_d4 = 0, r_w = 0;
    logic [2:0] r_exp = 3'b000;
    bit       r_act = 0;
    bit       r_wm = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            r_exp = 3'b000; r_run = 0; r_pos = 0; r_act = 0;
        end else begin
            r_act = r_run;
            r_wm  = r_w;
            r_exp = r_run ? exp_wave(r_pos, r_d4, r_w) : 3'b000;
            if (tick) begin
                if (!r_run || r_pos == (r_d4 ? 64 : 128) - 1) begin
                    r_run = 1; r_pos = 0; r_d4 = dec4; r_w = wide;
                end else begin
                    r_pos++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            logic [2:0] act;
            string tag;
            act = {conv_o, bitctl_o, bitclk_o};
            if (!r_act)                    tag = "R1";
            else if (act[2] !== r_exp[2])  tag = r_wm ? "R3" : "R5";
            else                           tag = r_wm ? "R4" : "R6";
            chk(act === r_exp, tag, "per-clock waveform", int'(act), int'(r_exp));
        end
    end

    // tick generator: 0 = hands off, 1 = every clock, 2 = pseudo-random, 3 = every third
    int tick_mode = 0;
    int div = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        case (tick_mode)
            1: tick <= 1'b1;
            2: begin
                lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tick <= lfsr[0] | lfsr[5];
            end
            3: begin
                div  <= (div == 2) ? 0 : div + 1;
                tick <= (div == 2);
            end
            default: ;
        endcase
    end

    // measure one frame from convert rise to the next convert rise
    task automatic measure(output int clks, output int br, output int ir, output int chi,
                           input int sw_at, input bit nd4, input bit nw);
        logic pc, pb, pi;
        pc = conv_o;
        forever begin
            @(negedge clk);
            if (conv_o && !pc) break;
            pc = conv_o;
        end
        clks = 0; br = 0; ir = 0; chi = 1;
        pc = conv_o; pb = bitctl_o; pi = bitclk_o;
        forever begin
            @(negedge clk);
            clks++;
            if (sw_at > 0 && clks == sw_at) begin
                dec4 = nd4; wide = nw;
            end
            if (bitctl_o && !pb) br++;
            if (bitclk_o && !pi) ir++;
            pb = bitctl_o; pi = bitclk_o;
            if (conv_o && !pc) break;
            if (conv_o) chi++;
            pc = conv_o;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL R2 watchdog expired: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int clks, br, ir, chi, changes;
        logic [2:0] snap;

        repeat (3) @(negedge clk);
        cmp_en = 1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk({conv_o, bitctl_o, bitclk_o} == 3'b000, "R1", "idle before first tick",
            int'({conv_o, bitctl_o, bitclk_o}), 0);

        // 32-clock pattern, decimate by 4, tick every clock
        tick_mode = 1;
        measure(clks, br, ir, chi, 0, 1'b1, 1'b1);
        measure(clks, br, ir, chi, 0, 1'b1, 1'b1);
        chk(clks == 64, "R2", "frame clocks dec4", clks, 64);
        chk(chi == 1,   "R3", "conv high wide", chi, 1);
        chk(br == 32,   "R4", "bitctl rises wide", br, 32);
        chk(ir == 32,   "R4", "bitclk rises wide", ir, 32);

        // mode flip inside a frame: this frame stays wide
        measure(clks, br, ir, chi, 10, 1'b1, 1'b0);
        chk(br == 32,   "R8", "bitctl rises in changed frame", br, 32);
        chk(chi == 1,   "R8", "conv high in changed frame", chi, 1);
        measure(clks, br, ir, chi, 0, 1'b1, 1'b0);
        chk(chi == 32,  "R5", "conv high narrow", chi, 32);
        chk(br == 16,   "R6", "bitctl rises narrow", br, 16);
        chk(ir == 16,   "R6", "bitclk rises narrow", ir, 16);
        chk(clks == 64, "R2", "frame clocks narrow dec4", clks, 64);

        // decimate by 2, tick every third clock
        tick_mode = 3;
        dec4 = 1'b0;
        measure(clks, br, ir, chi, 0, 1'b0, 1'b0);
        measure(clks, br, ir, chi, 0, 1'b0, 1'b0);
        chk(clks == 384, "R7", "frame clocks dec2", clks, 384);
        chk(chi == 192,  "R7", "conv high narrow dec2", chi, 192);
        chk(br == 16,    "R6", "bitctl rises narrow dec2", br, 16);
        wide = 1'b1;
        measure(clks, br, ir, chi, 0, 1'b0, 1'b1);
        measure(clks, br, ir, chi, 0, 1'b0, 1'b1);
        chk(chi == 6,    "R7", "conv high wide dec2", chi, 6);
        chk(br == 32,    "R4", "bitctl rises wide dec2", br, 32);

        // ratio flip inside a frame: this frame keeps 128 ticks
        measure(clks, br, ir, chi, 20, 1'b1, 1'b1);
        chk(clks == 384, "R8", "frame clocks after ratio flip", clks, 384);

        // no ticks: outputs hold
        tick_mode = 0;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
        snap = {conv_o, bitctl_o, bitclk_o};
        changes = 0;
        repeat (20) begin
            @(negedge clk);
            if ({conv_o, bitctl_o, bitclk_o} !== snap) changes++;
        end
        chk(changes == 0, "R9", "output changes without tick", changes, 0);

        // irregular ticks with mode changes
        tick_mode = 2;
        for (int k = 0; k < 6; k++) begin
            repeat (400) @(negedge clk);
            dec4 = k[0];
            wide = k[1];
        end

        // reset in the middle of a frame
        tick_mode = 1;
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk({conv_o, bitctl_o, bitclk_o} == 3'b000, "R10", "outputs in reset",
            int'({conv_o, bitctl_o, bitclk_o}), 0);
        tick_mode = 0;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({conv_o, bitctl_o, bitclk_o} == 3'b000, "R10", "idle after reset",
            int'({conv_o, bitctl_o, bitclk_o}), 0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        chk(conv_o == 1'b1, "R10", "conv after restart tick", int'(conv_o), 1);
        repeat (3) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end

endmodule